// File: doc/BRIEF.md
# Delay-Line Period Calibration Controller

This controller measures how many taps of a digital delay line fit into one period of the input clock. The delay line is laid out as a selection matrix of rows, each row holding a fixed number of taps. The first row of taps is duplicated, and every duplicated output is captured by its own flip-flop on the input clock. The result is a snapshot that shows how far the launched rising edge has travelled. The controller drives the row selection, moving from row to row. In each row it lets the line settle, then searches the snapshot for the point where the delayed edge meets the next clock edge.

When it finds that point, the controller forms the raw tap count as row times taps-per-row plus the position inside the row. It then subtracts a fixed correction for the residual clock-to-flip-flop delay of the sampling bank. The corrected count is latched and a done flag is raised. A run that finds no edge, or that ends with a corrected count of zero, raises an error flag. With a 27 MHz input clock and taps of about 200 ps, a healthy result is near 185 taps.

Top module: `dline_period_cal`

## Requirements
- R1: After reset, `done` and `calErr` are 0, `tapsPerPeriod` is 0 and `rowSel` is 0.
- R2: A `startPulse` sampled while idle or done clears `done` at that clock edge and sets `rowSel` to 0.
- R3: Each row is presented on `rowSel` for SETTLE_CYCLES settle cycles plus one evaluate cycle. `rowSel` then advances by exactly one. When the edge is found in row r, `done` rises at the (r+1)*(SETTLE_CYCLES+1)-th clock edge after the edge that sampled the start.
- R4: The edge position inside a row is the lowest index i (1..15) for which snapshot bit i-1 is 0 and snapshot bit i is 1. Snapshot bit i is tap i of the row.
- R5: A transition that straddles two rows counts as position 0 of the later row. This applies when bit 15 of the previous row's snapshot was 0 and bit 0 of the current row is 1. Row 0 never reports position 0.
- R6: The result is row*16 + position - CORR_TAPS (default 3). It is latched, and `done` together with the result holds for as long as no new start pulse arrives.
- R7: A row with no 0-to-1 transition is skipped. This covers all zeros, all ones, and patterns that only fall from 1 to 0. If all 24 rows are skipped, the run ends with `done`=1, `calErr`=1 and `tapsPerPeriod`=0 after 24*(SETTLE_CYCLES+1) edges.
- R8: If the raw count is not greater than CORR_TAPS, the result is 0 and `calErr` is 1. Any larger raw count gives `calErr`=0.
- R9: A `startPulse` that arrives while a calibration is running has no effect on the row sequence, the latency or the result.
- R10: When a snapshot holds several 0-to-1 transitions, the lowest one determines the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being measured |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to begin a calibration |
| snapshot | input | 16 | Captured outputs of the duplicated tap row, bit i = tap i |
| rowSel | output | 5 | Row selection driven into the delay-line matrix |
| tapsPerPeriod | output | 9 | Corrected taps-per-period result |
| done | output | 1 | Result valid; held until the next accepted start |
| calErr | output | 1 | Result out of range (zero or edge never found) |

## Verification
The assertions assume that `snapshot` is a function of the row currently selected and of the delay line, and that reset is applied before the first start. They also assume that `startPulse` can arrive in any state, so the checks on held results and on row stepping must hold even when start pulses arrive at random. The bench builds the snapshot from a model delay line: an edge threshold tap, with an optional override pattern for a single row. This keeps the snapshot consistent with `rowSel` at every edge. The bench changes the model only between runs, never during one.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_EVAL,
    ST_DONE
  } dlcalState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;    // restart: row 0, counter 0, clear result
    logic incCnt;    // advance settle counter
    logic advRow;    // move to next row, remember last tap of this row
    logic latchRes;  // store corrected result and error flag
  } dlcalStrobes_t;

endpackage

// File: rtl/dlcal_edge_find.sv
module dlcal_edge_find #(
  parameter int TAPS  = 16,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  snap,
  input  logic             prevLast,
  output logic             found,
  output logic [POS_W-1:0] pos
);

  logic [TAPS-1:0] trans;

  // transition into tap 0 comes from the previous row's last tap
  assign trans[0] = ~prevLast & snap[0];

  genvar g;
  generate
    for (g = 1; g < TAPS; g++) begin : gTrans
      assign trans[g] = ~snap[g-1] & snap[g];
    end
  endgenerate

  // lowest transition wins
  always_comb begin
    found = |trans;
    pos   = '0;
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (trans[i]) pos = POS_W'(i);
    end
  end

endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl
  import dlcal_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          cntLast,
  input  logic          rowLast,
  input  logic          edgeFound,
  output dlcalStrobes_t strobes,
  output logic          done
);

  dlcalState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (startPulse) begin
          strobes.clrRun = 1'b1;
          nextState      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        strobes.incCnt = 1'b1;
        if (cntLast) nextState = ST_EVAL;
      end
      ST_EVAL: begin
        if (edgeFound || rowLast) begin
          strobes.latchRes = 1'b1;
          nextState        = ST_DONE;
        end else begin
          strobes.advRow = 1'b1;
          nextState      = ST_SETTLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/dlcal_datapath.sv
module dlcal_datapath
  import dlcal_pkg::*;
#(
  parameter int ROWS          = 24,
  parameter int TAPS          = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int CORR_TAPS     = 3,
  localparam int ROW_W = $clog2(ROWS),
  localparam int POS_W = $clog2(TAPS),
  localparam int RES_W = $clog2(ROWS * TAPS),
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dlcalStrobes_t    strobes,
  input  logic [TAPS-1:0]  snapshot,
  output logic             cntLast,
  output logic             rowLast,
  output logic             edgeFound,
  output logic [ROW_W-1:0] rowSel,
  output logic [RES_W-1:0] tapsPerPeriod,
  output logic             calErr
);

  logic [ROW_W-1:0] rowReg;
  logic [CNT_W-1:0] settleCnt;
  logic             prevLast;
  logic [POS_W-1:0] edgePos;
  logic [RES_W:0]   rawTaps;
  logic             rawTooSmall;

  dlcal_edge_find #(.TAPS(TAPS), .POS_W(POS_W)) edgeFind_i (
    .snap     (snapshot),
    .prevLast (prevLast),
    .found    (edgeFound),
    .pos      (edgePos)
  );

  assign cntLast     = (settleCnt == CNT_W'(SETTLE_CYCLES - 1));
  assign rowLast     = (rowReg == ROW_W'(ROWS - 1));
  assign rawTaps     = (RES_W+1)'(rowReg) * (RES_W+1)'(TAPS) + (RES_W+1)'(edgePos);
  assign rawTooSmall = (rawTaps <= (RES_W+1)'(CORR_TAPS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg    <= '0;
      settleCnt <= '0;
      prevLast  <= 1'b1;
    end else if (strobes.clrRun) begin
      rowReg    <= '0;
      settleCnt <= '0;
      prevLast  <= 1'b1;
    end else if (strobes.advRow) begin
      rowReg    <= rowReg + 1'b1;
      settleCnt <= '0;
      prevLast  <= snapshot[TAPS-1];
    end else if (strobes.incCnt) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapsPerPeriod <= '0;
      calErr        <= 1'b0;
    end else if (strobes.clrRun) begin
      tapsPerPeriod <= '0;
      calErr        <= 1'b0;
    end else if (strobes.latchRes) begin
      if (!edgeFound || rawTooSmall) begin
        tapsPerPeriod <= '0;
        calErr        <= 1'b1;
      end else begin
        tapsPerPeriod <= RES_W'(rawTaps - (RES_W+1)'(CORR_TAPS));
        calErr        <= 1'b0;
      end
    end
  end

  assign rowSel = rowReg;

endmodule

// File: rtl/dline_period_cal.sv
module dline_period_cal
  import dlcal_pkg::*;
#(
  parameter int ROWS          = 24,
  parameter int TAPS          = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int CORR_TAPS     = 3,
  localparam int ROW_W = $clog2(ROWS),
  localparam int RES_W = $clog2(ROWS * TAPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [TAPS-1:0]  snapshot,
  output logic [ROW_W-1:0] rowSel,
  output logic [RES_W-1:0] tapsPerPeriod,
  output logic             done,
  output logic             calErr
);

  dlcalStrobes_t strobes;
  logic          cntLast;
  logic          rowLast;
  logic          edgeFound;

  dlcal_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .cntLast    (cntLast),
    .rowLast    (rowLast),
    .edgeFound  (edgeFound),
    .strobes    (strobes),
    .done       (done)
  );

  dlcal_datapath #(
    .ROWS          (ROWS),
    .TAPS          (TAPS),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .CORR_TAPS     (CORR_TAPS)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .snapshot      (snapshot),
    .cntLast       (cntLast),
    .rowLast       (rowLast),
    .edgeFound     (edgeFound),
    .rowSel        (rowSel),
    .tapsPerPeriod (tapsPerPeriod),
    .calErr        (calErr)
  );

endmodule

// File: rtl/dline_period_cal_chk.sv
module dline_period_cal_chk #(
  parameter int ROWS      = 24,
  parameter int TAPS      = 16,
  parameter int CORR_TAPS = 3,
  localparam int ROW_W = $clog2(ROWS),
  localparam int RES_W = $clog2(ROWS * TAPS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [ROW_W-1:0] rowSel,
  input logic [RES_W-1:0] tapsPerPeriod,
  input logic             done,
  input logic             calErr
);

  // R3: row selection never leaves the matrix
  a_r3_row_range: assert property (@(posedge clk) disable iff (!rstN)
    rowSel < ROW_W'(ROWS));

  // R3: row moves only forward by one, or back to row 0 on a restart
  a_r3_row_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowSel) |-> (rowSel == $past(rowSel) + 1'b1) || (rowSel == '0));

  // R2: accepted start drops done and restarts at row 0
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (done && startPulse) |=> (!done && rowSel == '0));

  // R6: result and flags hold while no start arrives
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> (done && $stable(tapsPerPeriod) && $stable(calErr)
                               && $stable(rowSel)));

  // R7 / R8: error flag coincides with a zero result
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (calErr == (tapsPerPeriod == '0)));

  // R6: corrected result cannot exceed the largest tap less the correction
  a_r6_result_bound: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(tapsPerPeriod) <= ROWS * TAPS - 1 - CORR_TAPS));

endmodule

bind dline_period_cal dline_period_cal_chk #(
  .ROWS      (ROWS),
  .TAPS      (TAPS),
  .CORR_TAPS (CORR_TAPS)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .startPulse    (startPulse),
  .rowSel        (rowSel),
  .tapsPerPeriod (tapsPerPeriod),
  .done          (done),
  .calErr        (calErr)
);

// File: tb/dline_period_cal_tb_top.sv
module dline_period_cal_tb_top;

  localparam int ROWS   = 24;
  localparam int TAPS   = 16;
  localparam int SETTLE = 4;
  localparam int CORR   = 3;
  localparam int ROW_TIME = SETTLE + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] snapshot;
  logic [4:0]  rowSel;
  logic [8:0]  tapsPerPeriod;
  logic        done;
  logic        calErr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // model delay line: tap t holds 1 once t >= edgeTap; one row may be overridden
  int          edgeTap = 1000;
  int          patRow  = -1;
  logic [15:0] patVal  = '0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < TAPS; i++) begin
      snapshot[i] = ((int'(rowSel) * TAPS + i) >= edgeTap);
    end
    if (int'(rowSel) == patRow) snapshot = patVal;
  end

  dline_period_cal #(
    .ROWS(ROWS), .TAPS(TAPS), .SETTLE_CYCLES(SETTLE), .CORR_TAPS(CORR)
  ) dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .snapshot      (snapshot),
    .rowSel        (rowSel),
    .tapsPerPeriod (tapsPerPeriod),
    .done          (done),
    .calErr        (calErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one calibration run; midAt > 0 pulses start again at that edge count
  task automatic run_cal(input string req, input int eTap, input int pRow,
                         input logic [15:0] pVal, input int expTaps,
                         input int expErr, input int expLat, input int midAt);
    int c = 0;
    int rowBad = 0;
    edgeTap = eTap;
    patRow  = pRow;
    patVal  = pVal;
    @(negedge clk);
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    check(done == 1'b0 && rowSel == 0, "R2 start clears", int'(done), 0);
    while (c < 400) begin
      @(posedge clk);
      c++;
      @(negedge clk);
      startPulse = 1'b0;
      if (done) break;
      if (int'(rowSel) != c / ROW_TIME) rowBad++;
      if (c == midAt) startPulse = 1'b1;
    end
    check(rowBad == 0, {req, " R3 row sequence"}, rowBad, 0);
    check(c == expLat, {req, " R3 latency"}, c, expLat);
    check(int'(tapsPerPeriod) == expTaps, {req, " result"}, int'(tapsPerPeriod), expTaps);
    check(int'(calErr) == expErr, {req, " calErr"}, int'(calErr), expErr);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(calErr == 1'b0, "R1 calErr", int'(calErr), 0);
    check(tapsPerPeriod == 0, "R1 taps", int'(tapsPerPeriod), 0);
    check(rowSel == 0, "R1 rowSel", int'(rowSel), 0);
  endtask

  task automatic t_nominal();
    // R4 R6: edge at tap 185 -> row 11 pos 9 -> 182
    run_cal("R4 R6 tap185", 185, -1, '0, 182, 0, 12 * ROW_TIME, 0);
    run_cal("R4 R6 tap37", 37, -1, '0, 34, 0, 3 * ROW_TIME, 0);
  endtask

  task automatic t_hold();
    int held = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!done || tapsPerPeriod != 9'd34) held++;
    end
    check(held == 0, "R6 done held", held, 0);
  endtask

  task automatic t_cross_row();
    // R5: edge at tap 32 -> row 2 pos 0 -> 29
    run_cal("R5 cross row", 32, -1, '0, 29, 0, 3 * ROW_TIME, 0);
    // R5: edge at tap 0 is never reported in row 0 -> exhausted
    run_cal("R5 row0 pos0", 0, -1, '0, 0, 1, ROWS * ROW_TIME, 0);
  endtask

  task automatic t_no_edge();
    run_cal("R7 all zeros", 1000, -1, '0, 0, 1, ROWS * ROW_TIME, 0);
    // R7: row 0 falls 1->0 only, skipped; edge at tap 70 -> 67
    run_cal("R7 falling row", 70, 0, 16'h00FF, 67, 0, 5 * ROW_TIME, 0);
  endtask

  task automatic t_small();
    run_cal("R8 raw below corr", 2, -1, '0, 0, 1, ROW_TIME, 0);
    run_cal("R8 raw above corr", 4, -1, '0, 1, 0, ROW_TIME, 0);
  endtask

  task automatic t_multi();
    // R10: row 3 = 0xF0A4, transitions at 2,5,7,12 -> lowest 2 -> 48+2-3
    run_cal("R10 lowest transition", 200, 3, 16'hF0A4, 47, 0, 4 * ROW_TIME, 0);
  endtask

  task automatic t_start_busy();
    run_cal("R9 start ignored", 185, -1, '0, 182, 0, 12 * ROW_TIME, 20);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_nominal();
    t_hold();
    t_cross_row();
    t_no_edge();
    t_small();
    t_multi();
    t_start_busy();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule